// File: doc/BRIEF.md
# Machine-Mode Control Register File

This block holds the machine-level trap and status registers of a small 32-bit core, together with a free-running 64-bit clock-cycle counter. Two clients reach it. The execute stage of the pipeline writes it and reads it on behalf of the decode stage. The interrupt controller writes it while taking or leaving a trap, and reads it through its own address.

Each client has a write port with its own enable, address and data, and a read port with its own address. Reads are combinational. Only the low 12 bits of any address select a register. The trap vector, the saved return address and the status word are also driven out continuously. The global interrupt-enable flag, taken from bit 3 of the status word, is driven out as well, so the interrupt controller can use these values without issuing a read.

Top module: `mcsr_file`

## Requirements
- R1: Only address bits [11:0] select a register. Bits above bit 11 on any read or write address have no effect.
- R2: The implemented registers sit at these 12-bit addresses: status 0x300, interrupt-enable 0x304, trap vector 0x305, scratch 0x340, return address 0x341, trap cause 0x342, cycle low half 0xB00, cycle high half 0xB80. Each of the six data registers stores all 32 written bits and reads them back on either read port.
- R3: Both read ports are combinational. A read returns the current register value in the same cycle its address is applied, with no clock edge needed.
- R4: A write on either port is visible from the clock edge on which its enable is sampled high. A read in the cycle before that edge still returns the old value.
- R5: When both write ports address the same register in one cycle, the execute-stage port's data is stored.
- R6: When the two write ports address different registers in one cycle, both writes are stored.
- R7: A read of any address not listed in R2 returns zero. A write to such an address changes no register.
- R8: The cycle counter is zero at reset and increases by one on every clock edge while reset is released. Address 0xB00 reads its low 32 bits and 0xB80 its high 32 bits. Writes to either counter address are ignored.
- R9: The global interrupt-enable output equals status bit 3. Status bit 7 is stored like any other bit and is independent of bit 3.
- R10: The trap-vector, return-address and status outputs always carry the current contents of registers 0x305, 0x341 and 0x300.
- R11: A synchronous active-low reset clears all six registers and the counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pipe_wr_en | input | 1 | Execute-stage write enable |
| pipe_wr_addr | input | ADDR_W | Execute-stage write address |
| pipe_wr_data | input | XLEN | Execute-stage write data |
| pipe_rd_addr | input | ADDR_W | Decode-side read address |
| pipe_rd_data | output | XLEN | Decode-side read data |
| irq_wr_en | input | 1 | Interrupt-controller write enable |
| irq_wr_addr | input | ADDR_W | Interrupt-controller write address |
| irq_wr_data | input | XLEN | Interrupt-controller write data |
| irq_rd_addr | input | ADDR_W | Interrupt-controller read address |
| irq_rd_data | output | XLEN | Interrupt-controller read data |
| trap_vec_o | output | XLEN | Current trap vector |
| ret_pc_o | output | XLEN | Current saved return address |
| status_o | output | XLEN | Current status word |
| glob_irq_en_o | output | 1 | Global interrupt enable (status bit 3) |

## Verification
The bench targets simultaneous writes. With both ports on the scratch register, a design that let the interrupt port win, or that merged the two data words, would read back the wrong value. With the ports on different registers, a single-winner arbiter would silently drop the interrupt controller's write. Addresses with high-order garbage and unmapped addresses such as 0x301 and 0x343 are also driven. A decoder that compares all address bits, or that aliases a neighbouring register, would then return data where zero is expected or corrupt a stored register. The counter is compared against an edge count kept by the bench, including after an attempted write to it. The enable output is checked while status bits 3 and 7 are toggled separately, which exposes a flag tapped from the wrong bit.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
   localparam int SEL_W = 12;
   localparam int NREG  = 6;

   localparam int IDX_STATUS  = 0;
   localparam int IDX_IE      = 1;
   localparam int IDX_TVEC    = 2;
   localparam int IDX_SCRATCH = 3;
   localparam int IDX_EPC     = 4;
   localparam int IDX_CAUSE   = 5;

   localparam logic [SEL_W-1:0] A_STATUS  = 12'h300;
   localparam logic [SEL_W-1:0] A_IE      = 12'h304;
   localparam logic [SEL_W-1:0] A_TVEC    = 12'h305;
   localparam logic [SEL_W-1:0] A_SCRATCH = 12'h340;
   localparam logic [SEL_W-1:0] A_EPC     = 12'h341;
   localparam logic [SEL_W-1:0] A_CAUSE   = 12'h342;
   localparam logic [SEL_W-1:0] A_CYC_LO  = 12'hB00;
   localparam logic [SEL_W-1:0] A_CYC_HI  = 12'hB80;

   function automatic logic [SEL_W-1:0] reg_addr(input int idx);
      case (idx)
         IDX_STATUS:  return A_STATUS;
         IDX_IE:      return A_IE;
         IDX_TVEC:    return A_TVEC;
         IDX_SCRATCH: return A_SCRATCH;
         IDX_EPC:     return A_EPC;
         default:     return A_CAUSE;
      endcase
   endfunction
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
   import mcsr_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NREG-1:0]   hit,
   output logic              cyc_lo,
   output logic              cyc_hi
);
   logic [SEL_W-1:0] sel;
   assign sel = addr[SEL_W-1:0];

   for (genvar i = 0; i < NREG; i++) begin : g_hit
      assign hit[i] = (sel == reg_addr(i));
   end

   assign cyc_lo = (sel == A_CYC_LO);
   assign cyc_hi = (sel == A_CYC_HI);
endmodule

// File: rtl/mcsr_cycle_ctr.sv
module mcsr_cycle_ctr #(
   parameter int CW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= count + CW'(1);
   end
endmodule

// File: rtl/mcsr_read_port.sv
module mcsr_read_port
   import mcsr_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic [NREG-1:0][XLEN-1:0]  regs,
   input  logic [2*XLEN-1:0]          cycles,
   output logic [XLEN-1:0]            data
);
   logic [NREG-1:0] hit;
   logic            cyc_lo, cyc_hi;

   mcsr_decode #(.ADDR_W(ADDR_W)) dec_i (
      .addr   (addr),
      .hit    (hit),
      .cyc_lo (cyc_lo),
      .cyc_hi (cyc_hi)
   );

   // Select lines are one-hot or all zero, so an OR tree is a full mux.
   always_comb begin
      data = '0;
      for (int i = 0; i < NREG; i++) begin
         if (hit[i]) data = data | regs[i];
      end
      if (cyc_lo) data = data | cycles[XLEN-1:0];
      if (cyc_hi) data = data | cycles[2*XLEN-1:XLEN];
   end
endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
   import mcsr_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_wr_en,
   input  logic [ADDR_W-1:0] pipe_wr_addr,
   input  logic [XLEN-1:0]   pipe_wr_data,
   input  logic [ADDR_W-1:0] pipe_rd_addr,
   output logic [XLEN-1:0]   pipe_rd_data,
   input  logic              irq_wr_en,
   input  logic [ADDR_W-1:0] irq_wr_addr,
   input  logic [XLEN-1:0]   irq_wr_data,
   input  logic [ADDR_W-1:0] irq_rd_addr,
   output logic [XLEN-1:0]   irq_rd_data,
   output logic [XLEN-1:0]   trap_vec_o,
   output logic [XLEN-1:0]   ret_pc_o,
   output logic [XLEN-1:0]   status_o,
   output logic              glob_irq_en_o
);
   localparam int CW       = 2 * XLEN;
   localparam int NPORT    = 2;
   localparam int MIE_BIT  = 3;

   if (ADDR_W < SEL_W) begin : g_bad_addr
      $error("mcsr_file: ADDR_W must be at least 12");
   end
   if (XLEN < 8) begin : g_bad_xlen
      $error("mcsr_file: XLEN must hold status bit 7");
   end

   logic [NREG-1:0][XLEN-1:0] csr_q;
   logic [CW-1:0]             cycle_cnt;
   logic [NREG-1:0]           pipe_hit, irq_hit;
   logic                      p_lo_unused, p_hi_unused, i_lo_unused, i_hi_unused;

   mcsr_cycle_ctr #(.CW(CW)) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .count (cycle_cnt)
   );

   mcsr_decode #(.ADDR_W(ADDR_W)) pipe_dec_i (
      .addr (pipe_wr_addr), .hit (pipe_hit),
      .cyc_lo (p_lo_unused), .cyc_hi (p_hi_unused)
   );
   mcsr_decode #(.ADDR_W(ADDR_W)) irq_dec_i (
      .addr (irq_wr_addr), .hit (irq_hit),
      .cyc_lo (i_lo_unused), .cyc_hi (i_hi_unused)
   );

   // Each register arbitrates on its own: the execute port wins only
   // where both ports target the same register.
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)                      csr_q[i] <= '0;
         else if (pipe_wr_en && pipe_hit[i]) csr_q[i] <= pipe_wr_data;
         else if (irq_wr_en && irq_hit[i])   csr_q[i] <= irq_wr_data;
      end
   end

   logic [NPORT-1:0][ADDR_W-1:0] rd_addr_v;
   logic [NPORT-1:0][XLEN-1:0]   rd_data_v;
   assign rd_addr_v[0] = pipe_rd_addr;
   assign rd_addr_v[1] = irq_rd_addr;

   for (genvar p = 0; p < NPORT; p++) begin : g_rd
      mcsr_read_port #(.XLEN(XLEN), .ADDR_W(ADDR_W)) rp_i (
         .addr   (rd_addr_v[p]),
         .regs   (csr_q),
         .cycles (cycle_cnt),
         .data   (rd_data_v[p])
      );
   end

   assign pipe_rd_data  = rd_data_v[0];
   assign irq_rd_data   = rd_data_v[1];
   assign trap_vec_o    = csr_q[IDX_TVEC];
   assign ret_pc_o      = csr_q[IDX_EPC];
   assign status_o      = csr_q[IDX_STATUS];
   assign glob_irq_en_o = csr_q[IDX_STATUS][MIE_BIT];
endmodule

// File: rtl/mcsr_file_chk.sv
module mcsr_file_chk
   import mcsr_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int ADDR_W = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      pipe_wr_en,
   input logic [ADDR_W-1:0]         pipe_wr_addr,
   input logic [XLEN-1:0]           pipe_wr_data,
   input logic [ADDR_W-1:0]         pipe_rd_addr,
   input logic [XLEN-1:0]           pipe_rd_data,
   input logic                      irq_wr_en,
   input logic [ADDR_W-1:0]         irq_wr_addr,
   input logic [XLEN-1:0]           irq_wr_data,
   input logic [XLEN-1:0]           ret_pc_o,
   input logic [XLEN-1:0]           status_o,
   input logic                      glob_irq_en_o,
   input logic [NREG-1:0][XLEN-1:0] csr_q,
   input logic [2*XLEN-1:0]         cycle_cnt
);
   localparam int CW = 2 * XLEN;

   logic pipe_rd_mapped;
   assign pipe_rd_mapped = pipe_rd_addr[SEL_W-1:0] inside
      {A_STATUS, A_IE, A_TVEC, A_SCRATCH, A_EPC, A_CAUSE, A_CYC_LO, A_CYC_HI};

   assert_glob_en_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_wr_en && pipe_wr_addr[SEL_W-1:0] == A_STATUS)
      |=> (glob_irq_en_o == $past(pipe_wr_data[3])));

   assert_cycle_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (cycle_cnt - $past(cycle_cnt) == CW'(1)));

   assert_exec_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_wr_en && irq_wr_en && pipe_wr_addr[SEL_W-1:0] == A_SCRATCH
       && irq_wr_addr[SEL_W-1:0] == A_SCRATCH)
      |=> (csr_q[IDX_SCRATCH] == $past(pipe_wr_data)));

   assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pipe_rd_mapped |-> (pipe_rd_data == '0));

   assert_epc_export_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_wr_en && irq_wr_addr[SEL_W-1:0] == A_EPC
       && !(pipe_wr_en && pipe_wr_addr[SEL_W-1:0] == A_EPC))
      |=> (ret_pc_o == $past(irq_wr_data)));

   assert_reset_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (status_o == '0 && cycle_cnt == '0));
endmodule

bind mcsr_file mcsr_file_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .pipe_wr_en    (pipe_wr_en),
   .pipe_wr_addr  (pipe_wr_addr),
   .pipe_wr_data  (pipe_wr_data),
   .pipe_rd_addr  (pipe_rd_addr),
   .pipe_rd_data  (pipe_rd_data),
   .irq_wr_en     (irq_wr_en),
   .irq_wr_addr   (irq_wr_addr),
   .irq_wr_data   (irq_wr_data),
   .ret_pc_o      (ret_pc_o),
   .status_o      (status_o),
   .glob_irq_en_o (glob_irq_en_o),
   .csr_q         (csr_q),
   .cycle_cnt     (cycle_cnt)
);

// File: tb/mcsr_file_tb_top.sv
module mcsr_file_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pipe_wr_en = 1'b0;
   logic [31:0] pipe_wr_addr = '0, pipe_wr_data = '0, pipe_rd_addr = '0;
   logic [31:0] pipe_rd_data;
   logic        irq_wr_en = 1'b0;
   logic [31:0] irq_wr_addr = '0, irq_wr_data = '0, irq_rd_addr = '0;
   logic [31:0] irq_rd_data, trap_vec_o, ret_pc_o, status_o;
   logic        glob_irq_en_o;

   int n_checks = 0;
   int n_bad    = 0;
   int tb_cyc   = 0;

   always #5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) tb_cyc <= 0;
      else        tb_cyc <= tb_cyc + 1;
   end

   mcsr_file dut_i (
      .clk (clk), .rst_n (rst_n),
      .pipe_wr_en (pipe_wr_en), .pipe_wr_addr (pipe_wr_addr),
      .pipe_wr_data (pipe_wr_data), .pipe_rd_addr (pipe_rd_addr),
      .pipe_rd_data (pipe_rd_data),
      .irq_wr_en (irq_wr_en), .irq_wr_addr (irq_wr_addr),
      .irq_wr_data (irq_wr_data), .irq_rd_addr (irq_rd_addr),
      .irq_rd_data (irq_rd_data),
      .trap_vec_o (trap_vec_o), .ret_pc_o (ret_pc_o),
      .status_o (status_o), .glob_irq_en_o (glob_irq_en_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pwr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      pipe_wr_en = 1'b1; pipe_wr_addr = a; pipe_wr_data = d;
      @(negedge clk);
      pipe_wr_en = 1'b0;
   endtask

   task automatic iwr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      irq_wr_en = 1'b1; irq_wr_addr = a; irq_wr_data = d;
      @(negedge clk);
      irq_wr_en = 1'b0;
   endtask

   task automatic rd_both(input string req, input logic [31:0] a, input logic [31:0] exp);
      pipe_rd_addr = a; irq_rd_addr = a;
      #1;
      chk({req, " pipe port"}, pipe_rd_data, exp);
      chk({req, " irq port"}, irq_rd_data, exp);
   endtask

   task automatic t_reset_state;
      rd_both("R11 reset status", 32'h300, 0);
      rd_both("R11 reset scratch", 32'h340, 0);
      rd_both("R11 reset cause", 32'h342, 0);
      chk("R11 reset status out", status_o, 0);
      chk("R11 reset vec out", trap_vec_o, 0);
      chk("R11 reset glob en", {31'b0, glob_irq_en_o}, 0);
   endtask

   task automatic t_map_each;
      logic [11:0] addrs [6] = '{12'h300, 12'h304, 12'h305, 12'h340, 12'h341, 12'h342};
      for (int i = 0; i < 6; i++) pwr({20'h0, addrs[i]}, 32'hA500_0000 + 32'(i) * 32'h1111);
      for (int i = 0; i < 6; i++)
         rd_both("R2 map readback", {20'h0, addrs[i]}, 32'hA500_0000 + 32'(i) * 32'h1111);
   endtask

   task automatic t_write_timing;
      @(negedge clk);
      pipe_wr_en = 1'b1; pipe_wr_addr = 32'h340; pipe_wr_data = 32'hDEAD_0001;
      pipe_rd_addr = 32'h340; #1;
      chk("R4 old value before edge", pipe_rd_data, 32'hA500_3333);
      @(negedge clk);
      pipe_wr_en = 1'b0;
      chk("R4 new value after edge", pipe_rd_data, 32'hDEAD_0001);
      iwr(32'h342, 32'h8000_0007);
      rd_both("R4 irq port write", 32'h342, 32'h8000_0007);
   endtask

   task automatic t_comb_read;
      @(negedge clk);
      pipe_rd_addr = 32'h304; #1;
      chk("R3 comb read a", pipe_rd_data, 32'hA500_1111);
      pipe_rd_addr = 32'h305; #1;
      chk("R3 comb read b", pipe_rd_data, 32'hA500_2222);
   endtask

   task automatic t_upper_bits;
      pwr(32'hABC0_0340, 32'h1234_5678);
      rd_both("R1 upper bits clear", 32'h0000_0340, 32'h1234_5678);
      rd_both("R1 upper bits set", 32'hFFFF_F340, 32'h1234_5678);
   endtask

   task automatic t_conflict;
      @(negedge clk);
      pipe_wr_en = 1'b1; pipe_wr_addr = 32'h340; pipe_wr_data = 32'h0000_AAAA;
      irq_wr_en  = 1'b1; irq_wr_addr  = 32'h340; irq_wr_data  = 32'h0000_5555;
      @(negedge clk);
      pipe_wr_addr = 32'h304; pipe_wr_data = 32'h0000_0888;
      irq_wr_addr  = 32'h342; irq_wr_data  = 32'h0000_000B;
      rd_both("R5 exec port wins", 32'h340, 32'h0000_AAAA);
      @(negedge clk);
      pipe_wr_en = 1'b0; irq_wr_en = 1'b0;
      rd_both("R6 both land ie", 32'h304, 32'h0000_0888);
      rd_both("R6 both land cause", 32'h342, 32'h0000_000B);
   endtask

   task automatic t_unmapped;
      rd_both("R7 unmapped 301 reads zero", 32'h301, 0);
      rd_both("R7 unmapped 7C0 reads zero", 32'h7C0, 0);
      pwr(32'h343, 32'hFFFF_FFFF);
      iwr(32'h301, 32'hFFFF_FFFF);
      rd_both("R7 scratch untouched", 32'h340, 32'h0000_AAAA);
      rd_both("R7 epc untouched", 32'h341, 32'hA500_4444);
      rd_both("R7 cause untouched", 32'h342, 32'h0000_000B);
      rd_both("R7 status untouched", 32'h300, 32'hA500_0000);
   endtask

   task automatic t_counter;
      @(negedge clk);
      rd_both("R8 cycle low", 32'hB00, 32'(tb_cyc));
      repeat (5) @(negedge clk);
      rd_both("R8 cycle low later", 32'hB00, 32'(tb_cyc));
      rd_both("R8 cycle high", 32'hB80, 0);
      pwr(32'hB00, 32'h0);
      pwr(32'hB80, 32'hFFFF_FFFF);
      rd_both("R8 write ignored low", 32'hB00, 32'(tb_cyc));
      rd_both("R8 write ignored high", 32'hB80, 0);
   endtask

   task automatic t_glob;
      pwr(32'h300, 32'h0000_0008);
      chk("R9 glob en set", {31'b0, glob_irq_en_o}, 1);
      pwr(32'h300, 32'h0000_0080);
      chk("R9 glob en clear with bit7", {31'b0, glob_irq_en_o}, 0);
      rd_both("R9 bit7 kept", 32'h300, 32'h0000_0080);
      iwr(32'h300, 32'h0000_0088);
      chk("R9 glob en via irq port", {31'b0, glob_irq_en_o}, 1);
   endtask

   task automatic t_exports;
      pwr(32'h305, 32'h0000_1000);
      iwr(32'h341, 32'h0000_2468);
      chk("R10 trap vector out", trap_vec_o, 32'h0000_1000);
      chk("R10 return pc out", ret_pc_o, 32'h0000_2468);
      chk("R10 status out", status_o, 32'h0000_0088);
   endtask

   task automatic t_mid_reset;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk("R11 mid reset vec", trap_vec_o, 0);
      chk("R11 mid reset epc", ret_pc_o, 0);
      rd_both("R11 mid reset ie", 32'h304, 0);
      rd_both("R11 mid reset cycle", 32'hB00, 0);
      @(negedge clk);
      rd_both("R8 first count after reset", 32'hB00, 1);
   endtask

   logic done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      t_map_each();
      t_write_timing();
      t_comb_read();
      t_upper_bits();
      t_conflict();
      t_unmapped();
      t_counter();
      t_glob();
      t_exports();
      t_mid_reset();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end
endmodule